// File: doc/BRIEF.md
# Pixel Histogram Bin Engine

This block keeps a table of 1024 counters, 24 bits wide, one per possible 10-bit pixel value. Each clock it takes a pixel value and uses it as a bin index. In histogram mode it adds one to that bin. In accumulate mode it adds a 24-bit data word to that bin instead. The new value is written back into the same bin and is also shown on a registered output bus. Sums wrap modulo 2^24.

An active-low start input gates the updates. While start is high, nothing is written, and the engine works as a lookup table: the output bus shows the stored content of the bin that the pixel addresses. The start input and the data word pass through the same three register stages as the pixel. A start level therefore applies to exactly the pixel sampled on the same edge.

Successive samples that hit the same bin take the unwritten sum from a forwarding register, so no increment is lost. An active-low clear request starts a sweep that writes zero to every bin, one bin per cycle. During the sweep, updates are held off and the output is held at zero. The same sweep also runs after reset. An active-low output enable gates the output bus.

The control is a two-state machine:
- State `ST_SWEEP` writes zero to one bin each cycle.
- State `ST_RUN` lets the pipeline run.
- Transition `sweep_done`: `ST_SWEEP` moves to `ST_RUN` after the last bin is written.
- Transition `clear_req`: `clr_n` low moves `ST_RUN` to `ST_SWEEP`. In `ST_SWEEP`, `clr_n` low restarts the sweep at bin 0.
- Reset enters `ST_SWEEP` at bin 0.

Top module: `hist_bin_engine`

## Requirements
- R1: After reset the output bus reads zero. Once the reset sweep has finished, a lookup of any bin returns zero.
- R2: In histogram mode (`acc_mode`=0), a pixel sampled with `start_n`=0 increments its bin by one.
- R3: The output bus shows the value written back for a pixel, in the cycle after the third rising edge counted from the edge that sampled that pixel.
- R4: A pixel sampled with `start_n`=1 leaves its bin unchanged, and the output bus shows the stored bin content at the same latency.
- R5: `start_n` passes through the same three-stage delay as the pixel, so each sample is updated or only read according to its own `start_n` level.
- R6: In accumulate mode (`acc_mode`=1), the `din` word sampled with the pixel is added to the bin in place of one.
- R7: Samples to the same bin on consecutive cycles each see the result of the previous sample, so no update is lost.
- R8: Bin sums wrap modulo 2^24, with no saturation.
- R9: A `clr_n` low level sampled on a clock edge zeroes every bin within 1024 cycles. Until that sweep has finished, the output bus stays at zero and pixels presented with `start_n`=0 change no bin.
- R10: With `oe_n`=1, `dout_oe` is 0 and `dout` is zero. With `oe_n`=0, `dout_oe` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset; starts a clearing sweep |
| clr_n | input | 1 | Active-low request to clear all bins |
| start_n | input | 1 | Active-low update enable, sampled with the pixel |
| acc_mode | input | 1 | 0 adds one per sample, 1 adds `din` |
| pix | input | 10 | Pixel value used as the bin index |
| din | input | 24 | Data word to add in accumulate mode |
| oe_n | input | 1 | Active-low output enable |
| dout | output | 24 | Updated or looked-up bin value; zero when not enabled |
| dout_oe | output | 1 | High when `dout` is being driven |

## Verification
Embedded properties check the following on every cycle:
- A sample to the same bin as the update just before it starts from that update's sum.
- No memory write happens for a sample taken with start high.
- The output stays at zero through a sweep.
- The sweep counter steps one bin at a time.
- The output is zero whenever the enable is off.

Only the bench scenarios can show the following, because they depend on bin contents built up over many samples:
- The actual bin totals after random histogram and accumulate streams.
- The 2^24 wrap.
- That pixels presented during a sweep leave no trace.
- That every bin reads zero once the sweep has finished.

// File: rtl/hist_pkg.sv
package hist_pkg;
    typedef enum logic {
        ST_SWEEP = 1'b0,
        ST_RUN   = 1'b1
    } eng_state_t;
endpackage

// File: rtl/hist_clear_fsm.sv
module hist_clear_fsm
    import hist_pkg::*;
#(
    parameter int ADDR_W = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr_n,
    output logic              sweeping,
    output logic              running,
    output logic [ADDR_W-1:0] sweep_addr
);
    localparam logic [ADDR_W-1:0] LAST_BIN = '1;

    eng_state_t        state;
    eng_state_t        state_nxt;
    logic [ADDR_W-1:0] cnt;

    // state register and sweep counter
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_SWEEP;
            cnt   <= '0;
        end else begin
            state <= state_nxt;
            if (!clr_n || state == ST_RUN) begin
                cnt <= '0;
            end else begin
                cnt <= cnt + 1'b1;
            end
        end
    end

    // transitions: sweep_done and clear_req
    always_comb begin
        state_nxt = state;
        unique case (state)
            ST_SWEEP: begin
                if (clr_n && cnt == LAST_BIN) begin
                    state_nxt = ST_RUN;
                end
            end
            ST_RUN: begin
                if (!clr_n) begin
                    state_nxt = ST_SWEEP;
                end
            end
        endcase
    end

    // outputs
    always_comb begin
        sweeping   = (state == ST_SWEEP);
        running    = (state == ST_RUN);
        sweep_addr = cnt;
    end

    p_sweep_step_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_SWEEP && clr_n && cnt != LAST_BIN)
        |=> (state == ST_SWEEP && cnt == $past(cnt) + 1'b1));

    p_sweep_exit_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_SWEEP && clr_n && cnt == LAST_BIN) |=> (state == ST_RUN));

    p_clear_enter_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !clr_n |=> (state == ST_SWEEP && cnt == '0));
endmodule

// File: rtl/hist_bin_ram.sv
module hist_bin_ram #(
    parameter int ADDR_W = 10,
    parameter int DATA_W = 24
) (
    input  logic              clk,
    input  logic              we,
    input  logic [ADDR_W-1:0] waddr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [ADDR_W-1:0] raddr,
    output logic [DATA_W-1:0] rdata
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) begin
            mem[waddr] <= wdata;
        end
        rdata <= mem[raddr];
    end
endmodule

// File: rtl/hist_bin_engine.sv
module hist_bin_engine #(
    parameter int ADDR_W = 10,
    parameter int DATA_W = 24
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr_n,
    input  logic              start_n,
    input  logic              acc_mode,
    input  logic [ADDR_W-1:0] pix,
    input  logic [DATA_W-1:0] din,
    input  logic              oe_n,
    output logic [DATA_W-1:0] dout,
    output logic              dout_oe
);
    localparam logic [DATA_W-1:0] ONE = DATA_W'(1);

    logic              sweeping;
    logic              running;
    logic [ADDR_W-1:0] sweep_addr;

    // stage 1: sampled request
    logic              v1, u1;
    logic [ADDR_W-1:0] a1;
    logic [DATA_W-1:0] inc1;
    // stage 2: memory read done
    logic              v2, u2;
    logic [ADDR_W-1:0] a2;
    logic [DATA_W-1:0] inc2;
    logic [DATA_W-1:0] rdata;
    // forwarding copy of the last update write
    logic              fw_v;
    logic [ADDR_W-1:0] fw_a;
    logic [DATA_W-1:0] fw_d;

    logic [DATA_W-1:0] base, sum, dout_q;
    logic              upd_we, ram_we;
    logic [ADDR_W-1:0] ram_waddr;
    logic [DATA_W-1:0] ram_wdata;

    hist_clear_fsm #(.ADDR_W(ADDR_W)) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .clr_n      (clr_n),
        .sweeping   (sweeping),
        .running    (running),
        .sweep_addr (sweep_addr)
    );

    hist_bin_ram #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_ram (
        .clk   (clk),
        .we    (ram_we),
        .waddr (ram_waddr),
        .wdata (ram_wdata),
        .raddr (a1),
        .rdata (rdata)
    );

    always_comb begin
        base      = (fw_v && fw_a == a2) ? fw_d : rdata;
        sum       = base + inc2;
        upd_we    = running && v2 && u2;
        ram_we    = sweeping || upd_we;
        ram_waddr = sweeping ? sweep_addr : a2;
        ram_wdata = sweeping ? '0 : sum;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            v1     <= 1'b0;
            u1     <= 1'b0;
            a1     <= '0;
            inc1   <= '0;
            v2     <= 1'b0;
            u2     <= 1'b0;
            a2     <= '0;
            inc2   <= '0;
            fw_v   <= 1'b0;
            fw_a   <= '0;
            fw_d   <= '0;
            dout_q <= '0;
        end else begin
            v1   <= running;
            u1   <= !start_n;
            a1   <= pix;
            inc1 <= acc_mode ? din : ONE;
            v2   <= v1 && running;
            u2   <= u1;
            a2   <= a1;
            inc2 <= inc1;
            fw_v <= upd_we;
            fw_a <= a2;
            fw_d <= sum;
            if (!running || !v2) begin
                dout_q <= '0;
            end else begin
                dout_q <= u2 ? sum : base;
            end
        end
    end

    always_comb begin
        dout_oe = !oe_n;
        dout    = dout_oe ? dout_q : '0;
    end

    p_fwd_chain_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_we && $past(upd_we) && a2 == $past(a2)) |-> (base == $past(sum)));

    p_lut_no_write_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (running && v2 && !u2) |-> !ram_we);

    p_lut_value_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (running && v2 && !u2) |=> (dout_q == $past(base)));

    p_sweep_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
        sweeping |=> (dout_q == '0));

    p_oe_gate_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !dout_oe |-> (dout == '0));
endmodule

// File: tb/hist_bin_engine_test.sv
`timescale 1ns/1ps
module hist_bin_engine_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        clr_n = 1'b1;
    logic        start_n = 1'b1;
    logic        acc_mode = 1'b0;
    logic [9:0]  pix = '0;
    logic [23:0] din = '0;
    logic        oe_n = 1'b0;
    logic [23:0] dout;
    logic        dout_oe;

    int total = 0;
    int fails = 0;
    bit done = 0;

    logic [23:0] mdl [1024];
    logic        qv [3];
    logic [23:0] qd [3];
    string       qt [3];

    always #2.5 clk = ~clk;

    hist_bin_engine uut (
        .clk(clk), .rst_n(rst_n), .clr_n(clr_n), .start_n(start_n),
        .acc_mode(acc_mode), .pix(pix), .din(din), .oe_n(oe_n),
        .dout(dout), .dout_oe(dout_oe)
    );

    task automatic expect_eq(input logic [23:0] act, input logic [23:0] exp, input string tag);
        total++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    function automatic logic [23:0] model_step(input logic [9:0] p, input logic s,
                                               input logic m, input logic [23:0] d);
        if (!s) mdl[p] = mdl[p] + (m ? d : 24'd1);
        return mdl[p];
    endfunction

    // one sample per clock; checks the sample driven three cycles earlier
    task automatic cyc(input logic [9:0] p, input logic s, input logic m,
                       input logic [23:0] d, input logic chk, input string tag);
        logic [23:0] e;
        @(negedge clk);
        if (qv[2]) expect_eq(dout, oe_n ? 24'd0 : qd[2], qt[2]);
        qv[2] = qv[1]; qd[2] = qd[1]; qt[2] = qt[1];
        qv[1] = qv[0]; qd[1] = qd[0]; qt[1] = qt[0];
        e = chk ? model_step(p, s, m, d) : 24'd0;
        qv[0] = chk; qd[0] = e; qt[0] = tag;
        pix = p; start_n = s; acc_mode = m; din = d;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) cyc(10'd0, 1'b1, 1'b0, 24'd0, 1'b0, "idle");
    endtask

    initial begin
        #1000000;
        if (!done) begin
            total++;
            fails++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("%0d/%0d checks passed", total - fails, total);
            $finish;
        end
    end

    initial begin
        logic [9:0] p;
        logic       s;
        int         seed;
        seed = $urandom(32'd48410);
        for (int i = 0; i < 1024; i++) mdl[i] = '0;
        for (int i = 0; i < 3; i++) begin qv[i] = 0; qd[i] = '0; qt[i] = ""; end

        // R1 reset state and R10 enable
        repeat (3) @(negedge clk);
        expect_eq(dout, 24'd0, "R1 dout in reset");
        expect_eq({23'd0, dout_oe}, 24'd1, "R10 dout_oe with oe_n=0");
        rst_n = 1'b1;
        idle(1100);
        cyc(10'd0, 1, 0, 0, 1, "R1 bin 0 after sweep");
        cyc(10'd5, 1, 0, 0, 1, "R1 bin 5 after sweep");
        cyc(10'd1023, 1, 0, 0, 1, "R1 bin 1023 after sweep");

        // R3 directed single update, then R4 lookup twice
        cyc(10'd512, 0, 0, 0, 1, "R3 single update");
        cyc(10'd512, 1, 0, 0, 1, "R4 lookup after update");
        cyc(10'd512, 1, 0, 0, 1, "R4 lookup unchanged");

        // R2/R5 random histogram with collisions and start gaps
        for (int i = 0; i < 400; i++) begin
            p = 10'($urandom_range(0, 7));
            s = ($urandom_range(0, 4) == 0);
            cyc(p, s, 0, 24'($urandom), 1, s ? "R5 start-high sample" : "R2 histogram");
        end

        // R7 back-to-back same bin
        for (int i = 0; i < 6; i++) cyc(10'd300, 0, 0, 0, 1, "R7 back-to-back bin 300");
        cyc(10'd300, 1, 0, 0, 1, "R7 bin 300 total");
        cyc(10'd300, 1, 0, 0, 1, "R4 bin 300 unchanged");

        // R6 accumulate mode random
        for (int i = 0; i < 300; i++) begin
            p = 10'($urandom_range(0, 15));
            s = ($urandom_range(0, 5) == 0);
            cyc(p, s, 1, 24'($urandom_range(0, 65535)), 1, s ? "R5 start-high in accumulate" : "R6 accumulate");
        end

        // R8 wrap
        cyc(10'd100, 0, 1, 24'hFFFFF0, 1, "R8 load near top");
        cyc(10'd100, 0, 1, 24'h000020, 1, "R8 wrap");
        cyc(10'd100, 1, 0, 0, 1, "R8 wrapped content");

        // R10 output enable off while running
        idle(3);
        oe_n = 1'b1;
        #0.5;
        expect_eq({23'd0, dout_oe}, 24'd0, "R10 dout_oe with oe_n=1");
        for (int i = 0; i < 8; i++) cyc(10'($urandom_range(0, 7)), 0, 0, 0, 1, "R10 gated output");
        idle(3);
        oe_n = 1'b0;
        cyc(10'd3, 1, 0, 0, 1, "R10 output restored");
        idle(3);

        // R9 clear with hold-off
        @(negedge clk); clr_n = 1'b0;
        @(negedge clk); clr_n = 1'b1;
        for (int i = 0; i < 1024; i++) mdl[i] = '0;
        for (int i = 0; i < 3; i++) qv[i] = 0;
        for (int i = 0; i < 20; i++) begin
            cyc(10'd3, 0, 0, 0, 0, "hold");
            expect_eq(dout, 24'd0, "R9 output zero during sweep");
        end
        idle(1100);
        cyc(10'd3, 1, 0, 0, 1, "R9 bin 3 cleared, no held-off update");
        cyc(10'd7, 1, 0, 0, 1, "R9 bin 7 cleared");
        cyc(10'd100, 1, 0, 0, 1, "R9 bin 100 cleared");
        cyc(10'd300, 1, 0, 0, 1, "R9 bin 300 cleared");
        cyc(10'd512, 1, 0, 0, 1, "R9 bin 512 cleared");
        cyc(10'd15, 0, 0, 0, 1, "R2 update after clear");
        idle(4);

        done = 1;
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end
endmodule